// File: doc/BRIEF.md
# Clock Level Transition Sequencer

This block moves a CPU clock domain from one operating level to another without software polling. A request names the current level and the target level. Five levels are supported: index 0 is the fastest (1200 MHz) and index 4 the slowest (200 MHz), with 1000, 800 and 500 MHz in between. For the target level, the block looks up the PLL multiplier, pre-divider and post-divider and two divider words in an internal table. It then drives the register-style outputs in the right order and waits on the status inputs between steps.

The sequencer picks one of two ways to reach the target. When the multiplier and pre-divider stay the same, only the 3-bit post-divider field of the PLL word is rewritten and the PLL stays locked. Otherwise the core clock is parked on the alternate PLL while the main PLL relocks. The divider words are written before the PLL change when the clock speeds up, and after it when the clock slows down.

The block reports busy, a one-cycle done pulse and a one-cycle error pulse. An error is raised when an index is out of range or when a wait step times out.

Top module: `clk_level_seq`

## Requirements
- R1: The PLL word keeps M in bits 25:16, P in bits 13:8 and S in bits 2:0. Every other bit keeps its value across all updates. The (M,P,S) values per level 0..4 are (150,3,1), (250,6,1), (200,6,1), (250,6,2) and (200,6,3). After reset the word holds `CFG_FIXED` ORed with the values of level `BOOT_LVL`.
- R2: When bits 31:8 of the packed (M,P,S) values are equal for the old and new levels, the only PLL step is a single write that changes bits 2:0. This write has no lock-time load and no mux switch. If those bits differ, a full relock is done.
- R3: A move to a lower index (faster clock) completes both divider writes before any PLL step. A move to a higher index completes the PLL step before the first divider write.
- R4: A full relock runs in this order:
  - set `mux_sel` to 0 (alternate) and wait until `mux_stat` equals 2;
  - pulse `lock_wr`;
  - write the new M/P/S;
  - wait for `pll_locked`;
  - set `mux_sel` to 1 (main) and wait until `mux_stat` equals 1.
- R5: A divider update does the following, in order:
  - write `div0_word`;
  - wait until `div0_stat` bits 0,4,8,12,16,20,24 are all 0;
  - write `div1_word`;
  - wait until `div1_stat` bits 0 and 4 are 0.
  Other status bits are ignored, and no status is evaluated in a write-strobe cycle.
- R6: `div0_word` packs 4-bit fields at bit 4k for k=0..6 (core, two memory-side ratios, peripheral, trace, debug, PLL output), with bits 31:28 zero. Per level these are 0,3,7,3,4,1,7 (levels 0 and 1), 0,3,7,3,3,1,7 (levels 2 and 3) and 0,1,3,1,3,1,0 (level 4). `div1_word` holds the copy ratio in bits 3:0: 5, 4, 3, 3, 3 for levels 0..4.
- R7: A request with equal old and new indices makes no register write. It gives one done pulse.
- R8: `busy` rises in the cycle after a request is accepted and stays high until done. A request made while `busy` is high is ignored.
- R9: `done` is a one-cycle pulse that follows the last wait of a transition.
- R10: If a wait step lasts `TMO_CYCLES` cycles, the block pulses `err`, returns to idle and gives no done.
- R11: A request with either index above 4 pulses `err`. It makes no write and does not raise `busy`.
- R12: Out of reset, `busy`, `done`, `err` and the strobes are low and `mux_sel` is 1. The divider words hold the `BOOT_LVL` values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Transition request strobe |
| req_old | input | 3 | Current level index |
| req_new | input | 3 | Target level index |
| mux_stat | input | 3 | Core mux status (1 main, 2 alternate) |
| pll_locked | input | 1 | Main PLL lock flag |
| div0_stat | input | 32 | First divider busy word |
| div1_stat | input | 32 | Second divider busy word |
| pll_cfg | output | 32 | PLL configuration word |
| pll_cfg_wr | output | 1 | Write strobe for `pll_cfg` |
| lock_time | output | LT_W | Lock-time value |
| lock_wr | output | 1 | Write strobe for `lock_time` |
| div0_word | output | 32 | First divider word |
| div0_wr | output | 1 | Write strobe for `div0_word` |
| div1_word | output | 32 | Second divider word |
| div1_wr | output | 1 | Write strobe for `div1_word` |
| mux_sel | output | 1 | Core mux select (1 main, 0 alternate) |
| busy | output | 1 | Transition in progress |
| done | output | 1 | Transition complete pulse |
| err | output | 1 | Rejection or timeout pulse |

## Verification
A chain of level moves covers all four path types: up with relock, down with relock, up post-divider only, and down post-divider only. The order of strobes and mux changes recorded for each move shows whether the direction rule and the relock decision were applied. The pairs 1↔3 and 2↔4 share M and P, so they separate the post-divider-only path from a relock. The status inputs carry unrelated set bits, which shows that only the named busy bits are masked in. Further tests cover:
- equal indices and out-of-range indices;
- a request made in the middle of a transition;
- a PLL that never locks, which checks the no-op, rejection, ignore and timeout paths.

// File: rtl/lvl_pkg.sv
package lvl_pkg;
  localparam int IDX_W = 3;
  localparam int LVL_N = 5;
  localparam logic [IDX_W-1:0] LVL_LAST = IDX_W'(LVL_N - 1);
  localparam logic [31:0] CFG_FIELDS = 32'h03FF_3F07;
  localparam logic [31:0] DIV0_BUSY  = 32'h0111_1111;
  localparam logic [31:0] DIV1_BUSY  = 32'h0000_0011;
  localparam logic [2:0]  MUX_ON_MAIN = 3'd1;
  localparam logic [2:0]  MUX_ON_ALT  = 3'd2;

  typedef enum logic [3:0] {
    ST_IDLE, ST_D0_WR, ST_D0_WT, ST_D1_WR, ST_D1_WT, ST_SFAST,
    ST_ALT, ST_ALT_WT, ST_LOCK_LD, ST_MPS_WR, ST_LOCK_WT,
    ST_MAIN, ST_MAIN_WT, ST_FIN
  } seq_st_t;

  function automatic logic [31:0] pack_mps(logic [9:0] m, logic [5:0] p, logic [2:0] s);
    return {6'b0, m, 2'b0, p, 5'b0, s};
  endfunction

  function automatic logic [31:0] lvl_mps(logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return pack_mps(10'd150, 6'd3, 3'd1);
      3'd1:    return pack_mps(10'd250, 6'd6, 3'd1);
      3'd2:    return pack_mps(10'd200, 6'd6, 3'd1);
      3'd3:    return pack_mps(10'd250, 6'd6, 3'd2);
      3'd4:    return pack_mps(10'd200, 6'd6, 3'd3);
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [31:0] div_word(logic [3:0] core, logic [3:0] cm0, logic [3:0] cm1,
                                           logic [3:0] peri, logic [3:0] trc, logic [3:0] dbg,
                                           logic [3:0] pllr);
    return {4'd0, pllr, dbg, trc, peri, cm1, cm0, core};
  endfunction

  function automatic logic [31:0] lvl_div0(logic [IDX_W-1:0] i);
    case (i)
      3'd0, 3'd1: return div_word(4'd0, 4'd3, 4'd7, 4'd3, 4'd4, 4'd1, 4'd7);
      3'd2, 3'd3: return div_word(4'd0, 4'd3, 4'd7, 4'd3, 4'd3, 4'd1, 4'd7);
      default:    return div_word(4'd0, 4'd1, 4'd3, 4'd1, 4'd3, 4'd1, 4'd0);
    endcase
  endfunction

  function automatic logic [31:0] lvl_div1(logic [IDX_W-1:0] i);
    case (i)
      3'd0:    return 32'd5;
      3'd1:    return 32'd4;
      default: return 32'd3;
    endcase
  endfunction
endpackage

// File: rtl/lvl_lookup.sv
module lvl_lookup import lvl_pkg::*; (
  input  logic [IDX_W-1:0] idx,
  output logic             ok,
  output logic [31:0]      mps
);
  assign ok  = (idx <= LVL_LAST);
  assign mps = lvl_mps(idx);
endmodule

// File: rtl/wait_guard.sv
module wait_guard #(
  parameter int LIMIT = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] CAP  = CW'(LIMIT);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)            cnt <= '0;
    else if (arm || !run)  cnt <= '0;
    else if (cnt != CAP)   cnt <= cnt + 1'b1;
  end

  assign expired = run && !arm && (cnt >= LAST);

  // R10: an expiry is only reported while a wait is active
  assert_guard_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0));
endmodule

// File: rtl/clk_level_seq.sv
module clk_level_seq import lvl_pkg::*; #(
  parameter int          TMO_CYCLES = 64,
  parameter int          LT_W       = 16,
  parameter logic [LT_W-1:0] LOCK_TIME = LT_W'(16'h0E10),
  parameter logic [31:0] CFG_FIXED  = 32'h8000_0000,
  parameter logic [2:0]  BOOT_LVL   = 3'd2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [IDX_W-1:0] req_old,
  input  logic [IDX_W-1:0] req_new,
  input  logic [2:0]       mux_stat,
  input  logic             pll_locked,
  input  logic [31:0]      div0_stat,
  input  logic [31:0]      div1_stat,
  output logic [31:0]      pll_cfg,
  output logic             pll_cfg_wr,
  output logic [LT_W-1:0]  lock_time,
  output logic             lock_wr,
  output logic [31:0]      div0_word,
  output logic             div0_wr,
  output logic [31:0]      div1_word,
  output logic             div1_wr,
  output logic             mux_sel,
  output logic             busy,
  output logic             done,
  output logic             err
);
  localparam logic [31:0] BOOT_CFG = CFG_FIXED | lvl_mps(BOOT_LVL);

  seq_st_t          state, nxt, after_div, after_pll;
  logic             entered;
  logic [IDX_W-1:0] tgt_q;
  logic             up_q, relock_q;
  logic [31:0]      tgt_mps;

  // request lookups for old and new level
  logic             lk_ok  [2];
  logic [31:0]      lk_mps [2];
  logic [IDX_W-1:0] lk_idx [2];
  assign lk_idx[0] = req_old;
  assign lk_idx[1] = req_new;

  for (genvar g = 0; g < 2; g++) begin : g_lk
    lvl_lookup u_lk (.idx(lk_idx[g]), .ok(lk_ok[g]), .mps(lk_mps[g]));
  end

  // named events
  logic req_ok, req_eq, req_up, req_relock, accept;
  assign req_ok     = lk_ok[0] && lk_ok[1];
  assign req_eq     = (req_old == req_new);
  assign req_up     = (req_new < req_old);
  assign req_relock = (lk_mps[0][31:8] != lk_mps[1][31:8]);
  assign accept     = (state == ST_IDLE) && req_valid && req_ok;

  logic ev_div0_clear, ev_div1_clear, ev_on_alt, ev_on_main;
  assign ev_div0_clear = ((div0_stat & DIV0_BUSY) == 32'h0);
  assign ev_div1_clear = ((div1_stat & DIV1_BUSY) == 32'h0);
  assign ev_on_alt     = (mux_stat == MUX_ON_ALT);
  assign ev_on_main    = (mux_stat == MUX_ON_MAIN);

  logic in_wait, wait_met, tmo;
  assign in_wait = (state == ST_D0_WT) || (state == ST_D1_WT) || (state == ST_ALT_WT) ||
                   (state == ST_LOCK_WT) || (state == ST_MAIN_WT);

  always_comb begin
    case (state)
      ST_D0_WT:   wait_met = ev_div0_clear;
      ST_D1_WT:   wait_met = ev_div1_clear;
      ST_ALT_WT:  wait_met = ev_on_alt;
      ST_LOCK_WT: wait_met = pll_locked;
      ST_MAIN_WT: wait_met = ev_on_main;
      default:    wait_met = 1'b0;
    endcase
  end

  wait_guard #(.LIMIT(TMO_CYCLES)) u_guard (
    .clk(clk), .rst_n(rst_n), .arm(entered), .run(in_wait), .expired(tmo)
  );

  assign tgt_mps   = lvl_mps(tgt_q);
  assign after_div = up_q ? (relock_q ? ST_ALT : ST_SFAST) : ST_FIN;
  assign after_pll = up_q ? ST_FIN : ST_D0_WR;

  logic settled;
  assign settled = !entered && wait_met;

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE: if (req_valid && req_ok) begin
        if (req_eq)          nxt = ST_FIN;
        else if (req_up)     nxt = ST_D0_WR;
        else if (req_relock) nxt = ST_ALT;
        else                 nxt = ST_SFAST;
      end
      ST_D0_WR:   nxt = ST_D0_WT;
      ST_D0_WT:   nxt = settled ? ST_D1_WR : (tmo ? ST_IDLE : state);
      ST_D1_WR:   nxt = ST_D1_WT;
      ST_D1_WT:   nxt = settled ? after_div : (tmo ? ST_IDLE : state);
      ST_SFAST:   nxt = after_pll;
      ST_ALT:     nxt = ST_ALT_WT;
      ST_ALT_WT:  nxt = settled ? ST_LOCK_LD : (tmo ? ST_IDLE : state);
      ST_LOCK_LD: nxt = ST_MPS_WR;
      ST_MPS_WR:  nxt = ST_LOCK_WT;
      ST_LOCK_WT: nxt = settled ? ST_MAIN : (tmo ? ST_IDLE : state);
      ST_MAIN:    nxt = ST_MAIN_WT;
      ST_MAIN_WT: nxt = settled ? after_pll : (tmo ? ST_IDLE : state);
      ST_FIN:     nxt = ST_IDLE;
      default:    nxt = ST_IDLE;
    endcase
  end

  logic tmo_hit;
  assign tmo_hit = tmo && !settled;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      entered    <= 1'b0;
      tgt_q      <= BOOT_LVL;
      up_q       <= 1'b0;
      relock_q   <= 1'b0;
      pll_cfg    <= BOOT_CFG;
      div0_word  <= lvl_div0(BOOT_LVL);
      div1_word  <= lvl_div1(BOOT_LVL);
      pll_cfg_wr <= 1'b0;
      lock_wr    <= 1'b0;
      div0_wr    <= 1'b0;
      div1_wr    <= 1'b0;
      mux_sel    <= 1'b1;
      err        <= 1'b0;
    end else begin
      state      <= nxt;
      entered    <= (nxt != state);
      pll_cfg_wr <= 1'b0;
      lock_wr    <= 1'b0;
      div0_wr    <= 1'b0;
      div1_wr    <= 1'b0;
      err        <= 1'b0;
      if (accept) begin
        tgt_q    <= req_new;
        up_q     <= req_up;
        relock_q <= req_relock;
      end
      if (state == ST_IDLE && req_valid && !req_ok) err <= 1'b1;
      if (in_wait && tmo_hit) err <= 1'b1;
      case (state)
        ST_D0_WR:   begin div0_word <= lvl_div0(tgt_q); div0_wr <= 1'b1; end
        ST_D1_WR:   begin div1_word <= lvl_div1(tgt_q); div1_wr <= 1'b1; end
        ST_SFAST:   begin pll_cfg <= {pll_cfg[31:3], tgt_mps[2:0]}; pll_cfg_wr <= 1'b1; end
        ST_ALT:     mux_sel <= 1'b0;
        ST_LOCK_LD: lock_wr <= 1'b1;
        ST_MPS_WR:  begin pll_cfg <= (pll_cfg & ~CFG_FIELDS) | tgt_mps; pll_cfg_wr <= 1'b1; end
        ST_MAIN:    mux_sel <= 1'b1;
        default:    ;
      endcase
    end
  end

  assign lock_time = LOCK_TIME;
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  // assertions next to the logic they guard
  assert_cfg_keep_R1: assert property (@(posedge clk) disable iff (!rst_n)
    pll_cfg_wr |-> ((pll_cfg & ~CFG_FIELDS) == ($past(pll_cfg) & ~CFG_FIELDS)));

  assert_sonly_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (pll_cfg_wr && mux_sel) |-> (pll_cfg[31:3] == $past(pll_cfg[31:3])));

  assert_lock_on_alt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lock_wr |-> !mux_sel);

  assert_div_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
    div1_wr |-> $past(ev_div0_clear, 2));

  assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(req_valid));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_tmo_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (in_wait && tmo_hit) |=> (err && !busy && !done));

  assert_bad_idx_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == ST_IDLE) && req_valid && !req_ok) |=> (err && !busy && !pll_cfg_wr && !div0_wr));
endmodule

// File: tb/sim_clk_level_seq.sv
module sim_clk_level_seq;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_old = 3'd0, req_new = 3'd0;
  logic [2:0]  mux_stat;
  logic        pll_locked;
  logic [31:0] div0_stat, div1_stat;
  logic [31:0] pll_cfg, div0_word, div1_word;
  logic [15:0] lock_time;
  logic        pll_cfg_wr, lock_wr, div0_wr, div1_wr, mux_sel, busy, done, err;

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_level_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_old(req_old), .req_new(req_new),
    .mux_stat(mux_stat), .pll_locked(pll_locked), .div0_stat(div0_stat), .div1_stat(div1_stat),
    .pll_cfg(pll_cfg), .pll_cfg_wr(pll_cfg_wr), .lock_time(lock_time), .lock_wr(lock_wr),
    .div0_word(div0_word), .div0_wr(div0_wr), .div1_word(div1_word), .div1_wr(div1_wr),
    .mux_sel(mux_sel), .busy(busy), .done(done), .err(err)
  );

  // environment model: divider busy, mux status lag, PLL lock
  logic [2:0] d0c, d1c, lk_cnt, mux_pipe;
  logic       lk_arm, lock_stuck = 1'b0;
  always @(posedge clk) begin
    if (!rst_n) begin
      d0c <= 3'd0; d1c <= 3'd0; mux_pipe <= 3'b111;
      pll_locked <= 1'b1; lk_arm <= 1'b0; lk_cnt <= 3'd0;
    end else begin
      d0c <= div0_wr ? 3'd3 : ((d0c != 3'd0) ? d0c - 3'd1 : 3'd0);
      d1c <= div1_wr ? 3'd3 : ((d1c != 3'd0) ? d1c - 3'd1 : 3'd0);
      mux_pipe <= {mux_pipe[1:0], mux_sel};
      if (lock_wr) begin pll_locked <= 1'b0; lk_arm <= 1'b1; end
      else if (pll_cfg_wr && lk_arm) begin lk_cnt <= 3'd5; lk_arm <= 1'b0; end
      else if (lk_cnt != 3'd0) begin
        lk_cnt <= lk_cnt - 3'd1;
        if (lk_cnt == 3'd1 && !lock_stuck) pll_locked <= 1'b1;
      end
    end
  end
  // unrelated status bits are held set to show the masking
  assign div0_stat = 32'h1000_0004 | ((d0c != 3'd0) ? 32'h0111_1111 : 32'h0);
  assign div1_stat = 32'h0000_0100 | ((d1c != 3'd0) ? 32'h0000_0011 : 32'h0);
  assign mux_stat  = mux_pipe[2] ? 3'd1 : 3'd2;

  // monitor: event codes 1=div0 2=div1 3=mux to alt 4=lock load 5=pll write 6=mux to main
  int          n_chk = 0, n_fail = 0, cyc = 0, evn = 0, n_done = 0, n_err = 0;
  logic [31:0] evlog = 32'h0;
  logic        busy_seen = 1'b0, mux_prev = 1'b1;

  task automatic log_ev(input int code);
    if (evn < 8) evlog = evlog | (32'(code) << (4 * evn));
    evn++;
  endtask

  always @(negedge clk) begin
    cyc++;
    if (rst_n) begin
      if (div0_wr)    log_ev(1);
      if (div1_wr)    log_ev(2);
      if (mux_sel != mux_prev) log_ev(mux_sel ? 6 : 3);
      if (lock_wr)    log_ev(4);
      if (pll_cfg_wr) log_ev(5);
      if (done) n_done++;
      if (err)  n_err++;
      if (busy) busy_seen = 1'b1;
    end
    mux_prev = mux_sel;
    if (cyc > 150000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog act=%0d exp=<150000 cycles", cyc);
      $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_div0(input logic [2:0] l);
    case (l)
      3'd0, 3'd1: return 32'h0714_3730;
      3'd2, 3'd3: return 32'h0713_3730;
      default:    return 32'h0013_1310;
    endcase
  endfunction
  function automatic logic [31:0] exp_div1(input logic [2:0] l);
    return (l == 3'd0) ? 32'd5 : ((l == 3'd1) ? 32'd4 : 32'd3);
  endfunction

  logic first_busy;
  task automatic start_req(input logic [2:0] o, input logic [2:0] n);
    @(negedge clk);
    evlog = 32'h0; evn = 0; n_done = 0; n_err = 0; busy_seen = 1'b0;
    req_old = o; req_new = n; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    first_busy = busy;
  endtask
  task automatic finish_req();
    for (int k = 0; k < 400; k++) begin
      if (done || err) break;
      @(negedge clk);
    end
    repeat (3) @(negedge clk);
  endtask

  // {old, new, expected event sequence (first event in low nibble), expected pll word}
  localparam logic [61:0] VEC [10] = '{
    {3'd2, 3'd0, 24'h654321, 32'h8096_0301},
    {3'd0, 3'd1, 24'h216543, 32'h80FA_0601},
    {3'd1, 3'd3, 24'h000215, 32'h80FA_0602},
    {3'd3, 3'd1, 24'h000521, 32'h80FA_0601},
    {3'd1, 3'd2, 24'h216543, 32'h80C8_0601},
    {3'd2, 3'd4, 24'h000215, 32'h80C8_0603},
    {3'd4, 3'd2, 24'h000521, 32'h80C8_0601},
    {3'd2, 3'd3, 24'h216543, 32'h80FA_0602},
    {3'd3, 3'd0, 24'h654321, 32'h8096_0301},
    {3'd0, 3'd4, 24'h216543, 32'h80C8_0603}
  };

  initial begin
    repeat (3) @(negedge clk);
    // R12 reset state
    chk("R12 busy", {31'b0, busy}, 32'd0);
    chk("R12 done/err", {30'b0, done, err}, 32'd0);
    chk("R12 strobes", {28'b0, pll_cfg_wr, lock_wr, div0_wr, div1_wr}, 32'd0);
    chk("R12 mux_sel", {31'b0, mux_sel}, 32'd1);
    chk("R1 R12 boot pll word", pll_cfg, 32'h80C8_0601);
    chk("R12 boot div0", div0_word, exp_div0(3'd2));
    chk("R12 boot div1", div1_word, exp_div1(3'd2));
    chk("lock time value", {16'b0, lock_time}, 32'h0000_0E10);
    rst_n = 1'b1;

    // vector walk: direction rule, relock choice, table values
    for (int i = 0; i < 10; i++) begin
      start_req(VEC[i][61:59], VEC[i][58:56]);
      finish_req();
      chk("R2 R3 R4 R5 event order", evlog, {8'h0, VEC[i][55:32]});
      chk("R1 R2 pll word", pll_cfg, VEC[i][31:0]);
      chk("R6 div0 word", div0_word, exp_div0(VEC[i][58:56]));
      chk("R6 div1 word", div1_word, exp_div1(VEC[i][58:56]));
      chk("R9 done pulse count", 32'(n_done), 32'd1);
      chk("R4 mux back on main", {31'b0, mux_sel}, 32'd1);
      chk("R8 busy after accept", {31'b0, first_busy}, 32'd1);
      chk("R10 no error", 32'(n_err), 32'd0);
    end

    // R7 equal indices
    start_req(3'd4, 3'd4);
    finish_req();
    chk("R7 no writes", evlog, 32'h0);
    chk("R7 done once", 32'(n_done), 32'd1);
    chk("R7 pll word kept", pll_cfg, 32'h80C8_0603);

    // R11 out-of-range indices
    start_req(3'd5, 3'd1);
    finish_req();
    chk("R11 err pulse", 32'(n_err), 32'd1);
    chk("R11 no writes", evlog, 32'h0);
    chk("R11 never busy", {31'b0, busy_seen}, 32'd0);
    start_req(3'd4, 3'd7);
    finish_req();
    chk("R11 err pulse new idx", 32'(n_err), 32'd1);
    chk("R11 no done", 32'(n_done), 32'd0);
    chk("R11 pll word kept", pll_cfg, 32'h80C8_0603);

    // R8 request while busy is ignored
    start_req(3'd4, 3'd1);
    repeat (5) @(negedge clk);
    chk("R8 busy mid transition", {31'b0, busy}, 32'd1);
    req_old = 3'd1; req_new = 3'd0; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    finish_req();
    chk("R8 only first request runs", evlog, 32'h0065_4321);
    chk("R8 pll word of first", pll_cfg, 32'h80FA_0601);
    chk("R8 single done", 32'(n_done), 32'd1);
    chk("R8 idle after", {31'b0, busy}, 32'd0);

    // R10 lock never arrives
    lock_stuck = 1'b1;
    start_req(3'd1, 3'd0);
    finish_req();
    chk("R10 err pulse", 32'(n_err), 32'd1);
    chk("R10 no done", 32'(n_done), 32'd0);
    chk("R10 idle after timeout", {31'b0, busy}, 32'd0);
    chk("R10 steps before stall", evlog, 32'h0005_4321);
    lock_stuck = 1'b0;

    // R12 reset again
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    chk("R12 word after reset", pll_cfg, 32'h80C8_0601);
    chk("R12 mux after reset", {31'b0, mux_sel}, 32'd1);

    $display("Result: errors=%0d of %0d checks", n_fail, n_chk);
    $finish;
  end
endmodule